// File: doc/BRIEF.md
# Patrol memory scrub engine

This block runs in the background next to an ECC-protected single-port memory. It walks a programmable window of word addresses in ascending order. For each word it reads the 72-bit codeword and checks it with a single-error-correct, double-error-detect code. A word with a one-bit error is written back in corrected form. A word with two flipped bits is reported as uncorrectable and left as it is. A clean word causes no write at all.

Reads are issued only in cycles where the host is not using the memory, so host traffic is never held up. Once a corrected word is pending, the engine keeps the port for the single write cycle that follows, even if the host has become busy. This makes the read-modify-write atomic with respect to host writes.

Passes are paced by a prescaler and a period counter. Two period values are held, a slow standard one and a fast extended one, and a select input picks between them. Every corrected or uncorrectable event is posted on a one-cycle report with its address. Two saturating counters accumulate the corrected and uncorrectable events until a clear pulse resets them.

Top module: `patrol_scrub`

## Requirements
- R1: Codeword layout: bits 63..0 hold data, bits 70..64 hold check bits c0..c6, and bit 71 makes the parity of all 72 bits even. Data bit k sits at Hamming position p(k), the k-th position in 3,5,6,7,9,...,71 (positions 1..71 that are not powers of two). Check bit ci is the even parity of the data bits whose p(k) has bit i set. A word with exactly one flipped bit, anywhere in the 72, produces in the cycle after its read data returns both a write of the clean codeword to the same address and a report with err_uncorr=0 and that address.
- R2: A word with exactly two flipped bits produces a report with err_uncorr=1 and its address, and no write.
- R3: A word that reads back clean produces neither a write nor a report.
- R4: A read request (mem_req=1, mem_we=0) is never issued in a cycle where host_busy is high.
- R5: The corrective write is issued in the cycle after the read response even if host_busy is high in that cycle.
- R6: Within a pass, addresses cfg_start through cfg_end inclusive are each read once, in ascending order, and nothing outside that window is read. A window covering the whole address space, including the last address, is supported.
- R7: With PRESC_DIV=P and the selected period N (cfg_period_fast if cfg_fast_sel=1, else cfg_period_slow), the first read of a pass comes N*P+1 cycles after the first read of the previous pass, when the pass finished sooner and the host is idle. If the pass takes longer, the next pass's first read comes two cycles after the read response of the last word, assuming that word is clean.
- R8: corr_cnt and unc_cnt count corrected and uncorrectable events and stop at their maximum value.
- R9: A one-cycle pulse on cnt_clr sets both counters to zero.
- R10: With cfg_en low no request is issued. When cfg_en rises, a read of cfg_start is issued in the following cycle if the host is idle.
- R11: Under reset, mem_req and err_valid are low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Scrubbing enable |
| cfg_start | input | ADDR_W | First word address of the window |
| cfg_end | input | ADDR_W | Last word address of the window |
| cfg_period_slow | input | PERIOD_W | Standard pass period, in prescaler ticks |
| cfg_period_fast | input | PERIOD_W | Extended-rate pass period, in prescaler ticks |
| cfg_fast_sel | input | 1 | 1 selects the fast period |
| cnt_clr | input | 1 | Clear pulse for both event counters |
| host_busy | input | 1 | Host is using the memory port this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 72 | Corrected codeword to write |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 72 | Read codeword |
| err_valid | output | 1 | One-cycle event report |
| err_uncorr | output | 1 | 1 = uncorrectable, 0 = corrected |
| err_addr | output | ADDR_W | Address of the reported word |
| corr_cnt | output | CNT_W | Saturating corrected-event count |
| unc_cnt | output | CNT_W | Saturating uncorrectable-event count |

## Verification
The bench builds the engine with ADDR_W=4, so a whole-memory pass of 16 words, including the wrap boundary at the last address, finishes in a few dozen cycles. PRESC_DIV=4 and PERIOD_W=8 give pass intervals of 81 and 21 cycles, which the bench measures exactly, and a period of one tick exercises the case where a pass outlasts its interval. CNT_W=2 makes the corrected counter saturate at 3 after only six injected single-bit errors.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

   localparam int DATA_W = 64;
   localparam int SYN_W  = 7;
   localparam int WORD_W = 72;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_READ,
      ST_RESP,
      ST_WRITE,
      ST_WAIT
   } scrub_st_e;

   // XOR of the Hamming positions of all set data bits
   function automatic logic [SYN_W-1:0] data_syndrome(input logic [DATA_W-1:0] d);
      logic [SYN_W-1:0] s;
      int k;
      s = '0;
      k = 0;
      for (int p = 1; p < WORD_W; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (d[k]) s = s ^ SYN_W'(p);
            k++;
         end
      end
      return s;
   endfunction

   function automatic logic [WORD_W-1:0] secded_encode(input logic [DATA_W-1:0] d);
      logic [WORD_W-1:0] w;
      w = '0;
      w[DATA_W-1:0] = d;
      w[DATA_W+SYN_W-1:DATA_W] = data_syndrome(d);
      w[WORD_W-1] = ^w[WORD_W-2:0];
      return w;
   endfunction

   // invert the data bit living at Hamming position syn (no-op for check positions)
   function automatic logic [DATA_W-1:0] flip_data(input logic [DATA_W-1:0] d,
                                                   input logic [SYN_W-1:0] syn);
      logic [DATA_W-1:0] r;
      int k;
      r = d;
      k = 0;
      for (int p = 1; p < WORD_W; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (SYN_W'(p) == syn) r[k] = ~r[k];
            k++;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/scrub_secded.sv
module scrub_secded
   import scrub_pkg::*;
(
   input  logic [WORD_W-1:0] word_in,
   output logic              single_err,
   output logic              double_err,
   output logic [WORD_W-1:0] fixed_word
);

   localparam logic [SYN_W-1:0] LAST_POS = SYN_W'(WORD_W - 1);

   logic [SYN_W-1:0]  syn;
   logic              odd;
   logic              in_range;
   logic [DATA_W-1:0] data_fix;

   always_comb begin
      syn        = data_syndrome(word_in[DATA_W-1:0]) ^ word_in[DATA_W+SYN_W-1:DATA_W];
      odd        = ^word_in;
      in_range   = (syn <= LAST_POS);
      single_err = odd && in_range;
      double_err = (!odd && (syn != '0)) || (odd && !in_range);
      data_fix   = (odd && in_range) ? flip_data(word_in[DATA_W-1:0], syn)
                                     : word_in[DATA_W-1:0];
      fixed_word = secded_encode(data_fix);
   end

endmodule

// File: rtl/scrub_pacer.sv
module scrub_pacer #(
   parameter int PERIOD_W  = 24,
   parameter int PRESC_DIV = 1024
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic [PERIOD_W-1:0] period,
   output logic                expired
);

   logic                tick;
   logic [PERIOD_W-1:0] cnt_q;

   generate
      if (PRESC_DIV == 1) begin : g_no_presc
         assign tick = 1'b1;
      end else begin : g_presc
         localparam int PW = $clog2(PRESC_DIV);
         localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              pre_q <= '0;
            else if (restart)        pre_q <= '0;
            else if (pre_q == LAST)  pre_q <= '0;
            else                     pre_q <= pre_q + PW'(1);
         end
         assign tick = (pre_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (restart)                cnt_q <= '0;
      else if (tick && (cnt_q != '1))  cnt_q <= cnt_q + PERIOD_W'(1);
   end

   assign expired = (cnt_q >= period);

   // a fresh interval has only expired if the period itself is zero
   p_fresh_interval_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (expired == (period == '0)));

endmodule

// File: rtl/scrub_sat_cnt.sv
module scrub_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (clr)                 count <= '0;
      else if (inc && count != TOP) count <= count + W'(1);
   end

   p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (count == TOP && inc && !clr) |=> (count == TOP));

   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (count != TOP && inc && !clr) |=> (count == $past(count) + W'(1)));

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));

endmodule

// File: rtl/patrol_scrub.sv
module patrol_scrub
   import scrub_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int PERIOD_W  = 24,
   parameter int PRESC_DIV = 1024,
   parameter int CNT_W     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_en,
   input  logic [ADDR_W-1:0]   cfg_start,
   input  logic [ADDR_W-1:0]   cfg_end,
   input  logic [PERIOD_W-1:0] cfg_period_slow,
   input  logic [PERIOD_W-1:0] cfg_period_fast,
   input  logic                cfg_fast_sel,
   input  logic                cnt_clr,
   input  logic                host_busy,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [WORD_W-1:0]   mem_wdata,
   input  logic                mem_rvalid,
   input  logic [WORD_W-1:0]   mem_rdata,
   output logic                err_valid,
   output logic                err_uncorr,
   output logic [ADDR_W-1:0]   err_addr,
   output logic [CNT_W-1:0]    corr_cnt,
   output logic [CNT_W-1:0]    unc_cnt
);

   localparam int N_KINDS = 2;

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("patrol_scrub: ADDR_W must be 1..32");
      end
      if (PERIOD_W < 1) begin : g_bad_period
         $error("patrol_scrub: PERIOD_W must be at least 1");
      end
      if (PRESC_DIV < 1) begin : g_bad_presc
         $error("patrol_scrub: PRESC_DIV must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("patrol_scrub: CNT_W must be at least 1");
      end
   endgenerate

   scrub_st_e           state_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [WORD_W-1:0]   fix_q;
   logic                rep_v_q;
   logic                rep_u_q;
   logic [ADDR_W-1:0]   rep_a_q;

   logic                dec_single;
   logic                dec_double;
   logic [WORD_W-1:0]   dec_fixed;
   logic                expired;
   logic                restart;
   logic                at_end;
   logic                resp_ok;
   logic                corr_evt;
   logic                unc_evt;
   logic [PERIOD_W-1:0] period_sel;
   logic [CNT_W-1:0]    cnt_arr [N_KINDS];

   scrub_secded u_dec (
      .word_in    (mem_rdata),
      .single_err (dec_single),
      .double_err (dec_double),
      .fixed_word (dec_fixed)
   );

   assign period_sel = cfg_fast_sel ? cfg_period_fast : cfg_period_slow;

   scrub_pacer #(.PERIOD_W(PERIOD_W), .PRESC_DIV(PRESC_DIV)) u_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .period  (period_sel),
      .expired (expired)
   );

   assign at_end   = (addr_q == cfg_end);
   assign resp_ok  = (state_q == ST_RESP) && mem_rvalid;
   assign corr_evt = resp_ok && dec_single;
   assign unc_evt  = resp_ok && dec_double;
   assign restart  = cfg_en && ((state_q == ST_OFF) || (state_q == ST_WAIT && expired));

   // port drive: reads only when the host is idle, the pending write always
   always_comb begin
      mem_req   = ((state_q == ST_READ) && cfg_en && !host_busy) || (state_q == ST_WRITE);
      mem_we    = (state_q == ST_WRITE);
      mem_addr  = addr_q;
      mem_wdata = fix_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
         addr_q  <= '0;
         fix_q   <= '0;
         rep_v_q <= 1'b0;
         rep_u_q <= 1'b0;
         rep_a_q <= '0;
      end else begin
         rep_v_q <= 1'b0;
         case (state_q)
            ST_OFF: begin
               if (cfg_en) begin
                  addr_q  <= cfg_start;
                  state_q <= ST_READ;
               end
            end
            ST_READ: begin
               if (!cfg_en)         state_q <= ST_OFF;
               else if (!host_busy) state_q <= ST_RESP;
            end
            ST_RESP: begin
               if (mem_rvalid) begin
                  if (dec_single || dec_double) begin
                     rep_v_q <= 1'b1;
                     rep_u_q <= dec_double;
                     rep_a_q <= addr_q;
                  end
                  if (dec_single) begin
                     fix_q   <= dec_fixed;
                     state_q <= ST_WRITE;
                  end else if (at_end) begin
                     state_q <= ST_WAIT;
                  end else begin
                     addr_q  <= addr_q + ADDR_W'(1);
                     state_q <= ST_READ;
                  end
               end
            end
            ST_WRITE: begin
               if (at_end) begin
                  state_q <= ST_WAIT;
               end else begin
                  addr_q  <= addr_q + ADDR_W'(1);
                  state_q <= ST_READ;
               end
            end
            ST_WAIT: begin
               if (!cfg_en) begin
                  state_q <= ST_OFF;
               end else if (expired) begin
                  addr_q  <= cfg_start;
                  state_q <= ST_READ;
               end
            end
            default: state_q <= ST_OFF;
         endcase
      end
   end

   assign err_valid  = rep_v_q;
   assign err_uncorr = rep_u_q;
   assign err_addr   = rep_a_q;

   generate
      for (genvar g = 0; g < N_KINDS; g++) begin : g_cnt
         scrub_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   ((g == 0) ? corr_evt : unc_evt),
            .count (cnt_arr[g])
         );
      end
   endgenerate

   assign corr_cnt = cnt_arr[0];
   assign unc_cnt  = cnt_arr[1];

   p_read_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> !host_busy);

   p_fix_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_ok && dec_single) |=> (mem_req && mem_we));

   p_report_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && !err_uncorr) |-> (mem_req && mem_we && mem_addr == err_addr));

   p_unc_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && err_uncorr) |-> !(mem_req && mem_we));

   p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_addr >= cfg_start && mem_addr <= cfg_end));

endmodule

// File: tb/patrol_scrub_tb_top.sv
module patrol_scrub_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int PW = 8;
   localparam int PD = 4;
   localparam int CW = 2;
   localparam int WW = 72;
   localparam int NWORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_en = 1'b0;
   logic [AW-1:0] cfg_start = '0;
   logic [AW-1:0] cfg_end = '0;
   logic [PW-1:0] cfg_period_slow = 8'd20;
   logic [PW-1:0] cfg_period_fast = 8'd5;
   logic          cfg_fast_sel = 1'b0;
   logic          cnt_clr = 1'b0;
   logic          host_busy = 1'b0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [WW-1:0] mem_wdata;
   logic          mem_rvalid = 1'b0;
   logic [WW-1:0] mem_rdata = '0;
   logic          err_valid, err_uncorr;
   logic [AW-1:0] err_addr;
   logic [CW-1:0] corr_cnt, unc_cnt;

   logic [WW-1:0] mem [NWORDS];
   logic          bd_we = 1'b0;
   logic [AW-1:0] bd_addr = '0;
   logic [WW-1:0] bd_data = '0;
   int            cyc = 0;

   int            total = 0;
   int            bad = 0;
   int            win_lo = 0;
   int            win_hi = 0;
   bit            busy_write_seen = 1'b0;
   int            start_times [$];
   int            wq_addr [$];
   logic [WW-1:0] wq_data [$];
   int            rq [$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   patrol_scrub #(.ADDR_W(AW), .PERIOD_W(PW), .PRESC_DIV(PD), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_start(cfg_start), .cfg_end(cfg_end),
      .cfg_period_slow(cfg_period_slow), .cfg_period_fast(cfg_period_fast),
      .cfg_fast_sel(cfg_fast_sel), .cnt_clr(cnt_clr), .host_busy(host_busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .err_valid(err_valid),
      .err_uncorr(err_uncorr), .err_addr(err_addr), .corr_cnt(corr_cnt), .unc_cnt(unc_cnt)
   );

   // memory model: one-cycle read latency, plus a backdoor write path for the bench
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req && !mem_we) begin
         mem_rvalid <= 1'b1;
         mem_rdata  <= mem[mem_addr];
      end
      if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
      if (bd_we) mem[bd_addr] <= bd_data;
   end

   // independent reference encoder following the layout stated in R1
   function automatic logic [WW-1:0] ref_enc(input logic [63:0] d);
      logic [WW-1:0] w;
      int k;
      w = '0;
      w[63:0] = d;
      k = 0;
      for (int p = 1; p <= 71; p++) begin
         if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
            for (int i = 0; i < 7; i++)
               if (p[i] && d[k]) w[64+i] = ~w[64+i];
            k++;
         end
      end
      w[71] = ^w[70:0];
      return w;
   endfunction

   function automatic logic [WW-1:0] clean_of(input int a);
      logic [63:0] d;
      d = {32'hC0DE_0000 | 32'(a), 32'h1234_5678 ^ (32'(a) * 32'h0101_0101)};
      return ref_enc(d);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic poke(input int a, input logic [WW-1:0] v);
      @(negedge clk);
      bd_addr = AW'(a);
      bd_data = v;
      bd_we   = 1'b1;
      @(negedge clk);
      bd_we   = 1'b0;
   endtask

   task automatic expect_fix(input int a);
      wq_addr.push_back(a);
      wq_data.push_back(clean_of(a));
      rq.push_back(a);
   endtask

   task automatic expect_unc(input int a);
      rq.push_back(256 + a);
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic monitor();
      int a;
      logic [WW-1:0] d;
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if (mem_req && !mem_we) begin
               if (host_busy) chk(1'b0, "R4 read issued while host busy", host_busy, 0);
               if (int'(mem_addr) < win_lo || int'(mem_addr) > win_hi)
                  chk(1'b0, "R6 read outside window", mem_addr, win_lo);
               if (mem_addr == cfg_start) start_times.push_back(cyc);
            end
            if (mem_req && mem_we) begin
               if (host_busy) busy_write_seen = 1'b1;
               if (wq_addr.size() == 0) begin
                  chk(1'b0, "R3 unexpected write", mem_addr, 0);
               end else begin
                  a = wq_addr.pop_front();
                  d = wq_data.pop_front();
                  chk(int'(mem_addr) == a, "R1 write-back address", mem_addr, a);
                  chk(mem_wdata == d, "R1 write-back codeword", mem_wdata, d);
               end
            end
            if (err_valid) begin
               if (rq.size() == 0) begin
                  chk(1'b0, "R3 unexpected report", {err_uncorr, err_addr}, 0);
               end else begin
                  a = rq.pop_front();
                  chk((int'(err_uncorr) * 256 + int'(err_addr)) == a, "R1 R2 report kind/address",
                      int'(err_uncorr) * 256 + int'(err_addr), a);
               end
            end
         end
      end
   endtask

   task automatic wait_starts(input int n);
      while (start_times.size() < n) @(negedge clk);
   endtask

   task automatic run_all();
      int reqs;
      // reset state, R11
      for (int a = 0; a < NWORDS; a++) poke(a, clean_of(a));
      @(negedge clk);
      chk(mem_req == 1'b0, "R11 mem_req in reset", mem_req, 0);
      chk(err_valid == 1'b0, "R11 err_valid in reset", err_valid, 0);
      chk(corr_cnt == 0, "R11 corr_cnt in reset", corr_cnt, 0);
      chk(unc_cnt == 0, "R11 unc_cnt in reset", unc_cnt, 0);
      rst_n = 1'b1;
      wait_cycles(3);

      // pass over 4..7: single data flip, double flip, check-bit flip
      cfg_start = 4; cfg_end = 7; win_lo = 4; win_hi = 7;
      poke(5, clean_of(5) ^ (72'd1 << 13));
      poke(6, clean_of(6) ^ (72'd1 << 2) ^ (72'd1 << 40));
      poke(7, clean_of(7) ^ (72'd1 << 67));
      expect_fix(5);
      expect_unc(6);
      expect_fix(7);
      @(negedge clk);
      cfg_en = 1'b1;
      @(negedge clk);
      chk(mem_req && !mem_we && mem_addr == 4, "R10 first read after enable", mem_addr, 4);
      wait_cycles(25);
      chk(rq.size() == 0 && wq_addr.size() == 0, "R1 R2 all expected events seen", rq.size(), 0);
      chk(mem[5] == clean_of(5), "R1 data bit repaired", mem[5], clean_of(5));
      chk(mem[7] == clean_of(7), "R1 check bit repaired", mem[7], clean_of(7));
      chk(mem[6] == (clean_of(6) ^ (72'd1 << 2) ^ (72'd1 << 40)), "R2 double error left alone",
          mem[6], clean_of(6) ^ (72'd1 << 2) ^ (72'd1 << 40));
      chk(corr_cnt == 2, "R8 corrected count", corr_cnt, 2);
      chk(unc_cnt == 1, "R8 uncorrectable count", unc_cnt, 1);
      poke(6, clean_of(6));
      wait_starts(2);
      chk(start_times[1] - start_times[0] == 20 * PD + 1, "R7 slow pass interval",
          start_times[1] - start_times[0], 20 * PD + 1);
      wait_cycles(20);
      chk(rq.size() == 0 && wq_addr.size() == 0, "R3 clean pass silent", rq.size(), 0);

      // disable: no requests, R10
      cfg_en = 1'b0;
      wait_cycles(4);
      reqs = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (mem_req) reqs++;
      end
      chk(reqs == 0, "R10 no requests while disabled", reqs, 0);

      // fast rate, R7
      cfg_fast_sel = 1'b1;
      start_times.delete();
      cfg_en = 1'b1;
      wait_starts(2);
      chk(start_times[1] - start_times[0] == 5 * PD + 1, "R7 fast pass interval",
          start_times[1] - start_times[0], 5 * PD + 1);
      cfg_en = 1'b0;
      wait_cycles(10);

      // pass outlasting its interval: 4 clean words, last response at +7, next read at +9
      cfg_period_fast = 8'd1;
      start_times.delete();
      cfg_en = 1'b1;
      wait_starts(2);
      chk(start_times[1] - start_times[0] == 9, "R7 back-to-back pass", start_times[1] - start_times[0], 9);
      cfg_en = 1'b0;
      wait_cycles(10);

      // saturation, busy during write-back, busy-gated reads: window 8..13
      cfg_fast_sel = 1'b0;
      cfg_start = 8; cfg_end = 13; win_lo = 8; win_hi = 13;
      poke(8, clean_of(8) ^ (72'd1 << 71));
      poke(9, clean_of(9) ^ (72'd1 << 0));
      poke(10, clean_of(10) ^ (72'd1 << 30));
      poke(11, clean_of(11) ^ (72'd1 << 50));
      expect_fix(8); expect_fix(9); expect_fix(10); expect_fix(11);
      busy_write_seen = 1'b0;
      start_times.delete();
      @(negedge clk);
      cfg_en = 1'b1;
      while (!(mem_req && !mem_we && mem_addr == 9)) @(negedge clk);
      @(negedge clk);
      host_busy = 1'b1;
      wait_cycles(6);
      host_busy = 1'b0;
      wait_cycles(30);
      chk(busy_write_seen, "R5 write-back completed under host busy", busy_write_seen, 1);
      chk(rq.size() == 0 && wq_addr.size() == 0, "R4 pass finished around busy window", rq.size(), 0);
      chk(mem[9] == clean_of(9), "R5 repaired word stored", mem[9], clean_of(9));
      chk(corr_cnt == 3, "R8 corrected count saturates", corr_cnt, 3);
      chk(unc_cnt == 1, "R8 uncorrectable count held", unc_cnt, 1);
      cfg_en = 1'b0;
      wait_cycles(3);
      cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
      chk(corr_cnt == 0 && unc_cnt == 0, "R9 counters cleared", {corr_cnt, unc_cnt}, 0);

      // whole memory including the last address, R6
      cfg_start = 0; cfg_end = 15; win_lo = 0; win_hi = 15;
      poke(0, clean_of(0) ^ (72'd1 << 64));
      poke(15, clean_of(15) ^ (72'd1 << 33));
      expect_fix(0);
      expect_fix(15);
      @(negedge clk);
      cfg_en = 1'b1;
      wait_cycles(50);
      chk(rq.size() == 0 && wq_addr.size() == 0, "R6 full-range events seen", rq.size(), 0);
      chk(mem[15] == clean_of(15), "R6 last address scrubbed", mem[15], clean_of(15));
      chk(mem[0] == clean_of(0), "R6 first address scrubbed", mem[0], clean_of(0));
      chk(corr_cnt == 2, "R8 count after full pass", corr_cnt, 2);
      cfg_en = 1'b0;
      wait_cycles(5);
   endtask

   initial begin
      for (int a = 0; a < NWORDS; a++) mem[a] = '0;
      fork
         monitor();
      join_none
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule